// File: doc/BRIEF.md
# PPS-Synchronized Device Time Counter

This block holds a 64-bit absolute device time counted in master-clock ticks. At the nominal 100 MHz clock each tick is 10 ns. The counter advances by one every cycle. A host controller steers it through a small command port. One command overwrites the time at once. Another stores a value that is copied into the time on the next rising edge of the pulse-per-second input. A third captures the current time and returns it on a read-data port.

A scheduling gate sits next to the counter. It holds one pending sample burst, tagged with an absolute device time, and pulses a release strobe when the time reaches that tag. The gate compares with greater-or-equal, so a time load that jumps past the tag still frees the burst. A burst whose tag has already passed when it arrives is released at once and marked late.

Top module: `devtime_sched`

## Requirements
- R1: During reset and in the first cycle after it, `time_now` is 0, `rd_valid`, `burst_go` and `burst_late` are 0, `burst_ready` is 1 and no PPS load is armed. `cmd_ready` is 0 while `rst` is high.
- R2: With no load, `time_now` increases by exactly one per clock and wraps from 2^64-1 to 0.
- R3: An accepted command with `cmd_op` = 0 (load now) makes `time_now` equal `cmd_value` in the next cycle, and counting resumes from it. It also cancels any armed PPS load.
- R4: An accepted command with `cmd_op` = 1 (load at PPS) arms a load of `cmd_value`. If `pps_in` is first seen high at clock edge k (low at edge k-1), `time_now` equals the armed value after edge k+2, without an added tick. The arm then clears, so later PPS edges have no effect.
- R5: A second `cmd_op` = 1 command replaces the stored value. If it is accepted in the same cycle as a PPS load, the older value loads and the new value stays armed for the following PPS edge.
- R6: An accepted command with `cmd_op` = 2 (read time) raises `rd_valid` for exactly one cycle, one cycle later. `rd_data` then equals the `time_now` shown in the accepting cycle.
- R7: An accepted command with `cmd_op` = 3 has no effect on the time, on the arm state or on the read port.
- R8: A burst is accepted when `burst_valid` and `burst_ready` are both high. `burst_ready` is low while a burst is pending. A pending burst with tag T raises `burst_go` for one cycle, in the first cycle whose `time_now` is at least T.
- R9: If the tag of an accepted burst is at most the `time_now` shown in the next cycle, `burst_go` pulses in that next cycle. `burst_late` pulses with it only when the tag is strictly smaller than that time.
- R10: A load-now command that moves the time past a pending tag releases the burst in the cycle the new time appears, without `burst_late`.
- R11: After reset `cmd_ready` is high every cycle, so one command is accepted per cycle. A PPS edge with nothing armed leaves the counting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_op | input | 2 | 0 load now, 1 load at PPS, 2 read time, 3 no operation |
| cmd_value | input | 64 | Time value for load commands |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| rd_data | output | 64 | Captured device time |
| time_now | output | 64 | Current device time |
| burst_valid | input | 1 | Burst offered for scheduling |
| burst_ready | output | 1 | No burst pending |
| burst_ts | input | 64 | Absolute release time of the offered burst |
| burst_go | output | 1 | One-cycle release strobe |
| burst_late | output | 1 | Release strobe for a tag already passed |

## Verification
Every result is due a fixed number of edges after its stimulus. A load now, a read strobe and a burst release all appear one edge after the accepting edge. A PPS load appears two edges after the edge that first samples `pps_in` high. A release for a time reached by counting shows in the same cycle as the matching `time_now`. The bench drives inputs on falling edges. A reference model in the bench advances on rising edges with the same latency counts, and all outputs are compared on the following falling edge. Directed steps then check these exact cycles with fixed values.

// File: rtl/devtime_pkg.sv
package devtime_pkg;
  localparam int TIME_W = 64;
  localparam int OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD_NOW = 2'd0,
    OP_LOAD_PPS = 2'd1,
    OP_READ     = 2'd2,
    OP_NOP      = 2'd3
  } time_op_e;
endpackage

// File: rtl/dt_pps_edge.sv
module dt_pps_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pps_async,
  output logic rise_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-2:0], pps_async};
  end

  // newest synchronized level high, one older low
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/dt_counter.sv
module dt_counter #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_now,
  input  logic          arm_pps,
  input  logic [TW-1:0] value,
  input  logic          pps_rise,
  output logic [TW-1:0] time_q,
  output logic [TW-1:0] time_d,
  output logic          armed_q,
  output logic [TW-1:0] arm_val_q
);
  logic pps_load;
  logic armed_d;

  assign pps_load = armed_q & pps_rise;

  always_comb begin
    if (load_now)      time_d = value;
    else if (pps_load) time_d = arm_val_q;
    else               time_d = time_q + TW'(1);
  end

  always_comb begin
    if (arm_pps)                    armed_d = 1'b1;
    else if (load_now || pps_load)  armed_d = 1'b0;
    else                            armed_d = armed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q    <= '0;
      armed_q   <= 1'b0;
      arm_val_q <= '0;
    end else begin
      time_q  <= time_d;
      armed_q <= armed_d;
      if (arm_pps) arm_val_q <= value;
    end
  end
endmodule

// File: rtl/dt_release.sv
module dt_release #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] time_d,
  input  logic          offer,
  input  logic [TW-1:0] offer_ts,
  output logic          free_o,
  output logic          go_q,
  output logic          late_q
);
  logic          pending_q;
  logic [TW-1:0] ts_q;
  logic          take;

  assign free_o = ~pending_q;
  assign take   = offer & ~pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      ts_q      <= '0;
      go_q      <= 1'b0;
      late_q    <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      late_q <= 1'b0;
      if (take) begin
        ts_q <= offer_ts;
        if (offer_ts <= time_d) begin
          go_q   <= 1'b1;
          late_q <= offer_ts < time_d;
        end else begin
          pending_q <= 1'b1;
        end
      end else if (pending_q && time_d >= ts_q) begin
        go_q      <= 1'b1;
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/devtime_sched.sv
module devtime_sched
  import devtime_pkg::*;
#(
  parameter int TW          = TIME_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [TW-1:0] cmd_value,
  input  logic          pps_in,
  output logic          rd_valid,
  output logic [TW-1:0] rd_data,
  output logic [TW-1:0] time_now,
  input  logic          burst_valid,
  output logic          burst_ready,
  input  logic [TW-1:0] burst_ts,
  output logic          burst_go,
  output logic          burst_late
);
  logic          ready_q;
  logic          fire;
  time_op_e      op;
  logic          pps_rise;
  logic [TW-1:0] time_q, time_d, arm_val;
  logic          armed;

  assign op        = time_op_e'(cmd_op);
  assign fire      = cmd_valid & ready_q;
  assign cmd_ready = ready_q;
  assign time_now  = time_q;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  dt_pps_edge #(.STAGES(SYNC_STAGES)) u_pps (
    .clk(clk), .rst(rst), .pps_async(pps_in), .rise_o(pps_rise)
  );

  dt_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst(rst),
    .load_now(fire && op == OP_LOAD_NOW),
    .arm_pps(fire && op == OP_LOAD_PPS),
    .value(cmd_value), .pps_rise(pps_rise),
    .time_q(time_q), .time_d(time_d),
    .armed_q(armed), .arm_val_q(arm_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= fire && op == OP_READ;
      if (fire && op == OP_READ) rd_data <= time_q;
    end
  end

  dt_release #(.TW(TW)) u_rel (
    .clk(clk), .rst(rst), .time_d(time_d),
    .offer(burst_valid), .offer_ts(burst_ts),
    .free_o(burst_ready), .go_q(burst_go), .late_q(burst_late)
  );
endmodule

// File: rtl/devtime_sched_chk.sv
module devtime_sched_chk #(
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [TW-1:0] cmd_value,
  input logic          rd_valid,
  input logic [TW-1:0] rd_data,
  input logic [TW-1:0] time_now,
  input logic          burst_ready,
  input logic          burst_go,
  input logic          burst_late,
  input logic          pps_rise,
  input logic          armed,
  input logic [TW-1:0] arm_val
);
  logic fire;
  assign fire = cmd_valid & cmd_ready;

  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    !(fire && (cmd_op == 2'd0)) && !(armed && pps_rise)
    |=> time_now == $past(time_now) + TW'(1));

  p_load_now_r3: assert property (@(posedge clk) disable iff (rst)
    fire && cmd_op == 2'd0 |=> time_now == $past(cmd_value));

  p_pps_load_r4: assert property (@(posedge clk) disable iff (rst)
    armed && pps_rise && !(fire && cmd_op == 2'd0) |=> time_now == $past(arm_val));

  p_read_r6: assert property (@(posedge clk) disable iff (rst)
    fire && cmd_op == 2'd2 |=> rd_valid && rd_data == $past(time_now));

  p_read_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    !(fire && cmd_op == 2'd2) |=> !rd_valid);

  p_go_frees_r8: assert property (@(posedge clk) disable iff (rst)
    burst_go |-> burst_ready);

  p_late_go_r9: assert property (@(posedge clk) disable iff (rst)
    burst_late |-> burst_go);

  p_ready_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cmd_ready);
endmodule

bind devtime_sched devtime_sched_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_value(cmd_value), .rd_valid(rd_valid),
  .rd_data(rd_data), .time_now(time_now), .burst_ready(burst_ready),
  .burst_go(burst_go), .burst_late(burst_late), .pps_rise(pps_rise),
  .armed(armed), .arm_val(arm_val)
);

// File: tb/devtime_sched_test.sv
module devtime_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd3;
  logic [TW-1:0] cmd_value = '0;
  logic          pps_in = 1'b0;
  logic          rd_valid;
  logic [TW-1:0] rd_data;
  logic [TW-1:0] time_now;
  logic          burst_valid = 1'b0;
  logic          burst_ready;
  logic [TW-1:0] burst_ts = '0;
  logic          burst_go;
  logic          burst_late;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  devtime_sched uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_value(cmd_value), .pps_in(pps_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .time_now(time_now),
    .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_ts(burst_ts),
    .burst_go(burst_go), .burst_late(burst_late)
  );

  // reference model built from the requirements
  logic [TW-1:0] m_time, m_arm, m_ts, m_rd;
  logic          m_armed, m_ready, m_pend, m_go, m_late, m_rdv;
  logic [2:0]    m_pps;

  function automatic logic [TW-1:0] next_time(logic [TW-1:0] t, logic ld_now,
      logic [TW-1:0] v, logic ld_pps, logic [TW-1:0] a);
    if (ld_now)      return v;
    else if (ld_pps) return a;
    return t + 64'd1;
  endfunction

  always @(posedge clk) begin : model
    logic fire, rise, ldp;
    logic [TW-1:0] nt;
    if (rst) begin
      m_time <= '0; m_arm <= '0; m_ts <= '0; m_rd <= '0;
      m_armed <= 1'b0; m_ready <= 1'b0; m_pend <= 1'b0;
      m_go <= 1'b0; m_late <= 1'b0; m_rdv <= 1'b0; m_pps <= '0;
    end else begin
      fire = cmd_valid && m_ready;
      rise = m_pps[1] && !m_pps[2];
      ldp  = m_armed && rise;
      nt   = next_time(m_time, fire && cmd_op == 2'd0, cmd_value, ldp, m_arm);
      m_time  <= nt;
      m_ready <= 1'b1;
      m_pps   <= {m_pps[1:0], pps_in};
      if (fire && cmd_op == 2'd1) begin m_armed <= 1'b1; m_arm <= cmd_value; end
      else if ((fire && cmd_op == 2'd0) || ldp) m_armed <= 1'b0;
      m_rdv <= fire && cmd_op == 2'd2;
      if (fire && cmd_op == 2'd2) m_rd <= m_time;
      m_go <= 1'b0; m_late <= 1'b0;
      if (burst_valid && !m_pend) begin
        m_ts <= burst_ts;
        if (burst_ts <= nt) begin m_go <= 1'b1; m_late <= burst_ts < nt; end
        else m_pend <= 1'b1;
      end else if (m_pend && nt >= m_ts) begin
        m_go <= 1'b1; m_pend <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 time", time_now, m_time);
      chk("R11 ready", 64'(cmd_ready), 64'(m_ready));
      chk("R6 rd_valid", 64'(rd_valid), 64'(m_rdv));
      if (m_rdv) chk("R6 rd_data", rd_data, m_rd);
      chk("R8 go", 64'(burst_go), 64'(m_go));
      chk("R9 late", 64'(burst_late), 64'(m_late));
      chk("R8 ready", 64'(burst_ready), 64'(!m_pend));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [TW-1:0] v);
    cmd_valid = 1'b1; cmd_op = op; cmd_value = v;
    tick(1);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic offer(input logic [TW-1:0] ts);
    burst_valid = 1'b1; burst_ts = ts;
    tick(1);
    burst_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [TW-1:0] t0;
    void'($urandom(32'd2024));
    tick(3);
    chk("R1 ready in reset", 64'(cmd_ready), 64'd0);
    chk("R1 time in reset", time_now, 64'd0);
    rst = 1'b0;
    tick(1);
    chk("R1 time after reset", time_now, 64'd1);
    chk("R1 burst_ready", 64'(burst_ready), 64'd1);
    chk("R1 go", 64'(burst_go), 64'd0);

    // load now and wrap
    cmd(2'd0, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R3 load now", time_now, 64'hFFFF_FFFF_FFFF_FFFE);
    tick(2);
    chk("R2 wrap", time_now, 64'd0);

    // PPS load timing
    cmd(2'd1, 64'd5000);
    pps_in = 1'b1;
    tick(3);
    chk("R4 pps load", time_now, 64'd5000);
    tick(1);
    chk("R4 counts on", time_now, 64'd5001);
    pps_in = 1'b0; tick(3);
    t0 = time_now;
    pps_in = 1'b1; tick(4); pps_in = 1'b0;
    chk("R11 unarmed pps", time_now, t0 + 64'd4);

    // replacement of the armed value
    tick(3);
    cmd(2'd1, 64'd7000);
    cmd(2'd1, 64'd9000);
    pps_in = 1'b1; tick(3);
    chk("R5 replaced value", time_now, 64'd9000);
    pps_in = 1'b0; tick(3);

    // arm in the same cycle as a PPS load
    cmd(2'd1, 64'd100);
    pps_in = 1'b1; tick(2);
    cmd(2'd1, 64'd300);
    chk("R5 older value loads", time_now, 64'd100);
    pps_in = 1'b0; tick(3);
    pps_in = 1'b1; tick(3);
    chk("R5 newer value on next pps", time_now, 64'd300);
    pps_in = 1'b0; tick(3);

    // load now cancels an armed load
    cmd(2'd1, 64'd1234);
    cmd(2'd0, 64'd50);
    pps_in = 1'b1; tick(3);
    chk("R3 cancel arm", time_now, 64'd53);
    pps_in = 1'b0; tick(3);

    // read and no-op
    t0 = time_now;
    cmd(2'd2, 64'd0);
    chk("R6 strobe", 64'(rd_valid), 64'd1);
    chk("R6 data", rd_data, t0);
    tick(1);
    chk("R6 one cycle", 64'(rd_valid), 64'd0);
    t0 = time_now;
    cmd(2'd3, 64'd77);
    chk("R7 no effect", time_now, t0 + 64'd1);
    chk("R7 no read", 64'(rd_valid), 64'd0);

    // bursts
    t0 = time_now;
    offer(t0 + 64'd10);
    chk("R8 pending", 64'(burst_ready), 64'd0);
    tick(8);
    chk("R8 not yet", 64'(burst_go), 64'd0);
    tick(1);
    chk("R8 release", 64'(burst_go), 64'd1);
    chk("R8 release time", time_now, t0 + 64'd10);
    t0 = time_now;
    offer(t0 - 64'd5);
    chk("R9 late go", 64'(burst_go), 64'd1);
    chk("R9 late flag", 64'(burst_late), 64'd1);
    t0 = time_now;
    offer(t0 + 64'd1);
    chk("R9 on time go", 64'(burst_go), 64'd1);
    chk("R9 on time no late", 64'(burst_late), 64'd0);
    t0 = time_now;
    offer(t0 + 64'd1000);
    cmd(2'd0, t0 + 64'd5000);
    chk("R10 jump release", 64'(burst_go), 64'd1);
    chk("R10 no late", 64'(burst_late), 64'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      cmd_valid   = ($urandom_range(0, 3) == 0);
      cmd_op      = 2'($urandom_range(0, 3));
      cmd_value   = m_time + 64'($urandom_range(0, 200)) - 64'd100;
      pps_in      = ($urandom_range(0, 15) < 4) ? ~pps_in : pps_in;
      burst_valid = ($urandom_range(0, 7) == 0);
      burst_ts    = m_time + 64'($urandom_range(0, 80)) - 64'd10;
      tick(1);
    end
    cmd_valid = 1'b0; burst_valid = 1'b0; pps_in = 1'b0;
    tick(5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule